// File: doc/BRIEF.md
# Time-Aligned Periodic Clock Output

This block drives a set of square-wave outputs whose edges line up with a free-running 64-bit nanosecond time value. Each channel is given a half-period in nanoseconds and an absolute 64-bit start time. Once software arms the channel, the output stays low until the time value reaches the start time. The output then goes high and inverts each time another half-period of time has passed. The full period is therefore always twice the programmed value.

The time value does not step by one nanosecond per clock. It advances by whatever increment the timebase applies. For that reason each channel keeps the time of its next edge and compares the incoming time against it. After each edge, the next-edge time grows by exactly one half-period, so the phase is set by the start time and not by the clock cycle in which an edge happened to be seen.

Software drives the block through a word-wide register port. It first writes zero to a channel's control word, then the half-period, then both halves of the start time, and finally the control word with the enable bit set and the mode field at its periodic value.

Top module: `tpg_wave_gen`

## Requirements
- R1: After reset every output is low and every register of every channel reads zero.
- R2: The register address is {channel, field}. Field 0 is control, field 1 is the half-period, field 2 is the start-time low word and field 3 is the start-time high word. In the control word, bit 0 is enable, bits 2:1 are mode and bit 3 is a read-only error flag. All writable fields read back as written.
- R3: An armed channel keeps its output low until the time value is at or past the start time. The output goes high one clock after the first cycle in which that holds.
- R4: After the first rising edge, the output inverts each time the time value reaches the next-edge time. The next-edge time begins at the start time and is increased by the half-period at every edge.
- R5: A channel runs only when its control word is written with enable = 1 and mode = 2'b11. Any other combination leaves the output low.
- R6: A run request made while the half-period is 3 or less sets the channel's error flag and keeps the output low. The next control write to that channel clears the flag, unless that write is again an illegal run request.
- R7: Writing a control word with enable = 0 clears that channel's half-period and start-time registers and forces its output low from the next clock.
- R8: Channels are independent. Writes to one channel never change another channel's output or registers.
- R9: A new run request to a channel that is already running restarts it from its current start time, and the output drops low until that time is reached.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | CHW+2 | Register address {channel, field}, used for both read and write |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data (combinational from reg_addr) |
| time_ns | input | 2*DW | Free-running nanosecond time value |
| wave_out | output | NCH | One square-wave output per channel |

## Verification
On every cycle, the assertions check the following:
- a waiting channel is low;
- an output changes only when the sampled time has passed the channel's next-edge time;
- each edge moves the next-edge time on by exactly one half-period;
- a disable write forces the output low and clears the half-period;
- a flagged channel never runs;
- arming happens only with a legal half-period;
- an active channel is always enabled.

The bench's scenarios are the only place the following can be shown:
- the exact cycle of the first edge relative to the start time;
- phase retention over long runs with different time increments, including a carry into the high time word;
- register readback;
- the restart on re-arm;
- channel independence.

// File: rtl/tpg_pkg.sv
package tpg_pkg;
  typedef enum logic [1:0] {
    FLD_CTRL = 2'd0,
    FLD_HALF = 2'd1,
    FLD_TLO  = 2'd2,
    FLD_THI  = 2'd3
  } fld_e;

  typedef enum logic [1:0] {
    CH_IDLE = 2'd0,
    CH_WAIT = 2'd1,
    CH_RUN  = 2'd2
  } chst_e;

  localparam logic [1:0] MODE_PERIODIC = 2'b11;
  localparam int CTRL_EN_BIT   = 0;
  localparam int CTRL_MODE_LSB = 1;
  localparam int CTRL_ERR_BIT  = 3;
endpackage

// File: rtl/tpg_regs.sv
module tpg_regs
  import tpg_pkg::*;
#(
  parameter int NCH      = 4,
  parameter int DW       = 32,
  parameter int MIN_HALF = 3,
  localparam int CHW     = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int AW      = CHW + 2,
  localparam int TW      = 2 * DW
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [AW-1:0]           addr,
  input  logic [DW-1:0]           wr_data,
  output logic [DW-1:0]           rd_data,
  output logic [NCH-1:0][DW-1:0]  half_o,
  output logic [NCH-1:0][TW-1:0]  tgt_o,
  output logic [NCH-1:0]          en_o,
  output logic [NCH-1:0]          err_o,
  output logic [NCH-1:0]          arm_o,
  output logic [NCH-1:0]          kill_o
);

  logic [NCH-1:0][1:0] mode_v;
  fld_e                fld;

  assign fld = fld_e'(addr[1:0]);

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic          ch_hit;
    logic          req_run;
    logic          legal;
    logic          en_q, en_d;
    logic [1:0]    mode_q, mode_d;
    logic          err_q, err_d;
    logic [DW-1:0] half_q, half_d;
    logic [DW-1:0] lo_q, lo_d;
    logic [DW-1:0] hi_q, hi_d;
    logic          arm_c, kill_c;

    assign ch_hit  = wr_en && (addr[AW-1:2] == CHW'(g));
    assign req_run = wr_data[CTRL_EN_BIT] &&
                     (wr_data[CTRL_MODE_LSB +: 2] == MODE_PERIODIC);
    assign legal   = half_q > DW'(MIN_HALF);

    always_comb begin
      en_d   = en_q;
      mode_d = mode_q;
      err_d  = err_q;
      half_d = half_q;
      lo_d   = lo_q;
      hi_d   = hi_q;
      arm_c  = 1'b0;
      kill_c = 1'b0;
      if (ch_hit) begin
        unique case (fld)
          FLD_CTRL: begin
            en_d   = wr_data[CTRL_EN_BIT];
            mode_d = wr_data[CTRL_MODE_LSB +: 2];
            if (req_run && legal) begin
              arm_c = 1'b1;
              err_d = 1'b0;
            end else begin
              kill_c = 1'b1;
              err_d  = req_run;
              if (!wr_data[CTRL_EN_BIT]) begin
                half_d = '0;
                lo_d   = '0;
                hi_d   = '0;
              end
            end
          end
          FLD_HALF: half_d = wr_data;
          FLD_TLO:  lo_d   = wr_data;
          FLD_THI:  hi_d   = wr_data;
          default:  ;
        endcase
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        en_q   <= 1'b0;
        mode_q <= '0;
        err_q  <= 1'b0;
        half_q <= '0;
        lo_q   <= '0;
        hi_q   <= '0;
      end else if (ch_hit) begin
        en_q   <= en_d;
        mode_q <= mode_d;
        err_q  <= err_d;
        half_q <= half_d;
        lo_q   <= lo_d;
        hi_q   <= hi_d;
      end
    end

    assign half_o[g] = half_q;
    assign tgt_o[g]  = {hi_q, lo_q};
    assign en_o[g]   = en_q;
    assign err_o[g]  = err_q;
    assign mode_v[g] = mode_q;
    assign arm_o[g]  = arm_c;
    assign kill_o[g] = kill_c;
  end

  always_comb begin
    rd_data = '0;
    for (int c = 0; c < NCH; c++) begin
      if (addr[AW-1:2] == CHW'(c)) begin
        unique case (fld)
          FLD_CTRL: begin
            rd_data[CTRL_EN_BIT]          = en_o[c];
            rd_data[CTRL_MODE_LSB +: 2]   = mode_v[c];
            rd_data[CTRL_ERR_BIT]         = err_o[c];
          end
          FLD_HALF: rd_data = half_o[c];
          FLD_TLO:  rd_data = tgt_o[c][DW-1:0];
          FLD_THI:  rd_data = tgt_o[c][TW-1:DW];
          default:  ;
        endcase
      end
    end
  end

endmodule

// File: rtl/tpg_chan.sv
module tpg_chan
  import tpg_pkg::*;
#(
  parameter int DW  = 32,
  localparam int TW = 2 * DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm,
  input  logic          kill,
  input  logic [DW-1:0] half,
  input  logic [TW-1:0] target,
  input  logic [TW-1:0] time_ns,
  output logic          wave,
  output logic          waiting,
  output logic          running,
  output logic [TW-1:0] next_edge
);

  chst_e         st_q, st_d;
  logic [TW-1:0] nx_q, nx_d;
  logic          w_q, w_d;
  logic          hit;
  logic          upd;

  assign hit = time_ns >= nx_q;

  always_comb begin
    st_d = st_q;
    nx_d = nx_q;
    w_d  = w_q;
    unique case (st_q)
      CH_WAIT: begin
        if (hit) begin
          st_d = CH_RUN;
          w_d  = 1'b1;
          nx_d = nx_q + TW'(half);
        end
      end
      CH_RUN: begin
        if (hit) begin
          w_d  = ~w_q;
          nx_d = nx_q + TW'(half);
        end
      end
      default: ;
    endcase
    if (kill) begin
      st_d = CH_IDLE;
      w_d  = 1'b0;
      nx_d = '0;
    end else if (arm) begin
      st_d = CH_WAIT;
      w_d  = 1'b0;
      nx_d = target;
    end
  end

  assign upd = kill || arm || (st_q != CH_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= CH_IDLE;
      nx_q <= '0;
      w_q  <= 1'b0;
    end else if (upd) begin
      st_q <= st_d;
      nx_q <= nx_d;
      w_q  <= w_d;
    end
  end

  assign wave      = w_q;
  assign waiting   = (st_q == CH_WAIT);
  assign running   = (st_q == CH_RUN);
  assign next_edge = nx_q;

endmodule

// File: rtl/tpg_wave_gen.sv
module tpg_wave_gen
  import tpg_pkg::*;
#(
  parameter int NCH      = 4,
  parameter int DW       = 32,
  parameter int MIN_HALF = 3,
  localparam int CHW     = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int AW      = CHW + 2,
  localparam int TW      = 2 * DW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           reg_wr,
  input  logic [AW-1:0]  reg_addr,
  input  logic [DW-1:0]  reg_wdata,
  output logic [DW-1:0]  reg_rdata,
  input  logic [TW-1:0]  time_ns,
  output logic [NCH-1:0] wave_out
);

  logic                   rs_meta, rs_sync;
  logic [NCH-1:0][DW-1:0] half_vec;
  logic [NCH-1:0][TW-1:0] tgt_vec;
  logic [NCH-1:0][TW-1:0] nx_vec;
  logic [NCH-1:0]         en_vec, err_vec, arm_vec, kill_vec;
  logic [NCH-1:0]         wait_vec, run_vec;

  // reset: asserted at once, released through two flops
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_meta <= 1'b0;
      rs_sync <= 1'b0;
    end else begin
      rs_meta <= 1'b1;
      rs_sync <= rs_meta;
    end
  end

  tpg_regs #(
    .NCH(NCH), .DW(DW), .MIN_HALF(MIN_HALF)
  ) regs_i (
    .clk(clk), .rst_n(rs_sync),
    .wr_en(reg_wr), .addr(reg_addr), .wr_data(reg_wdata), .rd_data(reg_rdata),
    .half_o(half_vec), .tgt_o(tgt_vec), .en_o(en_vec), .err_o(err_vec),
    .arm_o(arm_vec), .kill_o(kill_vec)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    tpg_chan #(.DW(DW)) chan_i (
      .clk(clk), .rst_n(rs_sync),
      .arm(arm_vec[g]), .kill(kill_vec[g]),
      .half(half_vec[g]), .target(tgt_vec[g]), .time_ns(time_ns),
      .wave(wave_out[g]), .waiting(wait_vec[g]), .running(run_vec[g]),
      .next_edge(nx_vec[g])
    );
  end

endmodule

// File: rtl/tpg_wave_gen_chk.sv
module tpg_wave_gen_chk #(
  parameter int NCH      = 4,
  parameter int DW       = 32,
  parameter int MIN_HALF = 3,
  localparam int CHW     = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int AW      = CHW + 2,
  localparam int TW      = 2 * DW
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   reg_wr,
  input logic [AW-1:0]          reg_addr,
  input logic                   wen_bit,
  input logic [TW-1:0]          time_ns,
  input logic [NCH-1:0]         wave_out,
  input logic [NCH-1:0]         wait_vec,
  input logic [NCH-1:0]         run_vec,
  input logic [NCH-1:0]         err_vec,
  input logic [NCH-1:0]         en_vec,
  input logic [NCH-1:0][TW-1:0] nx_vec,
  input logic [NCH-1:0][DW-1:0] half_vec
);

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    p_wait_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
      wait_vec[c] |-> !wave_out[c]);

    p_toggle_due_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!$stable(wave_out[c]) && run_vec[c]) |-> ($past(time_ns) >= $past(nx_vec[c])));

    p_edge_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (run_vec[c] && $past(run_vec[c]) && !$stable(nx_vec[c]))
        |-> (nx_vec[c] == $past(nx_vec[c]) + TW'($past(half_vec[c]))));

    p_active_enabled_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (wait_vec[c] || run_vec[c]) |-> en_vec[c]);

    p_err_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      err_vec[c] |-> (!wave_out[c] && !run_vec[c] && !wait_vec[c]));

    p_arm_legal_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wait_vec[c]) |-> (half_vec[c] > DW'(MIN_HALF)));

    p_disable_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && (reg_addr == {CHW'(c), 2'b00}) && !wen_bit)
        |=> (!wave_out[c] && (half_vec[c] == '0)));
  end

endmodule

bind tpg_wave_gen tpg_wave_gen_chk #(
  .NCH(NCH), .DW(DW), .MIN_HALF(MIN_HALF)
) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .wen_bit(reg_wdata[0]), .time_ns(time_ns), .wave_out(wave_out),
  .wait_vec(wait_vec), .run_vec(run_vec), .err_vec(err_vec), .en_vec(en_vec),
  .nx_vec(nx_vec), .half_vec(half_vec)
);

// File: tb/tpg_wave_gen_tb_top.sv
module tpg_wave_gen_tb_top;
  localparam int NCH = 4;
  localparam int DW  = 32;
  localparam int TW  = 64;
  localparam int AW  = 4;

  logic           clk;
  logic           rst_n;
  logic           reg_wr;
  logic [AW-1:0]  reg_addr;
  logic [DW-1:0]  reg_wdata;
  logic [DW-1:0]  reg_rdata;
  logic [TW-1:0]  time_ns;
  logic [NCH-1:0] wave_out;

  int n_cmp, n_bad;
  bit mon_on, done;
  logic [TW-1:0] inc;

  // reference model state
  logic [NCH-1:0]         m_en, m_err, m_out;
  logic [NCH-1:0][1:0]    m_mode;
  logic [NCH-1:0][DW-1:0] m_half;
  logic [NCH-1:0][TW-1:0] m_tgt, m_nx;
  int                     m_st [NCH];

  tpg_wave_gen #(.NCH(NCH), .DW(DW), .MIN_HALF(3)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .time_ns(time_ns),
    .wave_out(wave_out)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [DW-1:0] exp_rd(input int ch, input int fld);
    case (fld)
      0: exp_rd = {28'd0, m_err[ch], m_mode[ch], m_en[ch]};
      1: exp_rd = m_half[ch];
      2: exp_rd = m_tgt[ch][31:0];
      default: exp_rd = m_tgt[ch][63:32];
    endcase
  endfunction

  function automatic bit run_req(input logic [DW-1:0] w);
    run_req = w[0] && (w[2:1] == 2'b11);
  endfunction

  // model updated from the same sampled inputs as the design
  always @(posedge clk) begin
    if (!rst_n) begin
      m_en = '0; m_err = '0; m_out = '0; m_mode = '0;
      m_half = '0; m_tgt = '0; m_nx = '0;
      for (int c = 0; c < NCH; c++) m_st[c] = 0;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (m_st[c] != 0 && time_ns >= m_nx[c]) begin
          if (m_st[c] == 1) begin m_out[c] = 1'b1; m_st[c] = 2; end
          else m_out[c] = ~m_out[c];
          m_nx[c] = m_nx[c] + TW'(m_half[c]);
        end
      end
      if (reg_wr) begin
        automatic int c = int'(reg_addr[3:2]);
        case (reg_addr[1:0])
          2'd0: begin
            m_en[c] = reg_wdata[0]; m_mode[c] = reg_wdata[2:1];
            if (run_req(reg_wdata) && m_half[c] > 3) begin
              m_st[c] = 1; m_nx[c] = m_tgt[c]; m_out[c] = 1'b0; m_err[c] = 1'b0;
            end else begin
              m_st[c] = 0; m_out[c] = 1'b0; m_err[c] = run_req(reg_wdata);
              if (!reg_wdata[0]) begin m_half[c] = '0; m_tgt[c] = '0; end
            end
          end
          2'd1: m_half[c] = reg_wdata;
          2'd2: m_tgt[c][31:0] = reg_wdata;
          default: m_tgt[c][63:32] = reg_wdata;
        endcase
      end
    end
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic wr(input int ch, input int fld, input logic [DW-1:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = {2'(ch), 2'(fld)}; reg_wdata = d;
    @(posedge clk);
    #1 reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input int ch, input int fld, input string req);
    logic [DW-1:0] e;
    @(negedge clk);
    reg_addr = {2'(ch), 2'(fld)};
    #1;
    e = exp_rd(ch, fld);
    check(reg_rdata === e, req, 64'(reg_rdata), 64'(e));
  endtask

  task automatic prog(input int ch, input logic [DW-1:0] h, input logic [TW-1:0] t, input logic [1:0] mode);
    wr(ch, 0, '0);
    wr(ch, 1, h);
    wr(ch, 2, t[31:0]);
    wr(ch, 3, t[63:32]);
    wr(ch, 0, {29'd0, mode, 1'b1});
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // time base, advanced at the falling edge
  initial begin
    time_ns = 64'h0000_0001_FFFF_FF00;
    inc = 64'd3;
    forever begin
      @(negedge clk);
      time_ns = time_ns + inc;
    end
  end

  // output monitor: R3 R4 R5 R8 R9 against the model every cycle
  initial begin
    forever begin
      @(negedge clk);
      if (mon_on)
        check(wave_out === m_out, "R3 R4 R8 R9 wave", 64'(wave_out), 64'(m_out));
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    n_cmp = 0; n_bad = 0; mon_on = 1'b0; done = 1'b0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    idle(4);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    check(wave_out === '0, "R1 wave", 64'(wave_out), 64'd0);
    for (int c = 0; c < NCH; c++)
      for (int f = 0; f < 4; f++) rd_chk(c, f, "R1 reg");
    mon_on = 1'b1;

    // R2 readback
    wr(1, 1, 32'hA5A5_0011);
    wr(1, 2, 32'h1234_5678);
    wr(1, 3, 32'h9ABC_DEF0);
    for (int f = 1; f < 4; f++) rd_chk(1, f, "R2 field");

    // R5 wrong mode keeps low
    prog(2, 32'd8, time_ns, 2'b01);
    rd_chk(2, 0, "R5 ctrl");
    idle(40);
    check(wave_out[2] === 1'b0, "R5 mode01", 64'(wave_out[2]), 64'd0);

    // R3 R4 main run on ch0, far target stays low first
    prog(0, 32'd10, time_ns + 64'd600, 2'b11);
    idle(20);
    check(wave_out[0] === 1'b0, "R3 before target", 64'(wave_out[0]), 64'd0);
    idle(300);
    // R8 second channel running alongside
    prog(1, 32'd7, time_ns + 64'd30, 2'b11);
    idle(150);

    // R9 re-arm ch1 with far target
    wr(1, 2, 32'(time_ns[31:0] + 32'd5000));
    wr(1, 3, time_ns[63:32]);
    wr(1, 0, 32'd7);
    idle(5);
    check(wave_out[1] === 1'b0, "R9 rearm low", 64'(wave_out[1]), 64'd0);

    // R6 illegal half
    prog(3, 32'd3, time_ns, 2'b11);
    rd_chk(3, 0, "R6 err set");
    check(exp_rd(3, 0) === 32'd15, "R6 err value", 64'(exp_rd(3, 0)), 64'd15);
    idle(30);
    check(wave_out[3] === 1'b0, "R6 low", 64'(wave_out[3]), 64'd0);
    wr(3, 0, 32'd0);
    rd_chk(3, 0, "R6 err clear");

    // R7 disable running ch0
    wr(0, 0, 32'd6);
    @(negedge clk);
    check(wave_out[0] === 1'b0, "R7 low", 64'(wave_out[0]), 64'd0);
    for (int f = 1; f < 4; f++) rd_chk(0, f, "R7 cleared");

    // random programs with varied increments
    for (int i = 0; i < 40; i++) begin
      automatic int ch = int'($urandom % NCH);
      automatic logic [DW-1:0] h = ($urandom % 8 == 0) ? DW'($urandom % 4) : DW'(4 + $urandom % 40);
      automatic logic [1:0] md = ($urandom % 10 == 0) ? 2'b01 : 2'b11;
      inc = TW'(1 + $urandom % 6);
      prog(ch, h, time_ns + TW'($urandom % 300), md);
      idle(10 + int'($urandom % 100));
      rd_chk(ch, 0, "R2 R6 ctrl");
      if (i % 7 == 0) begin
        automatic int k = int'($urandom % NCH);
        wr(k, 0, 32'd0);
        rd_chk(k, 1, "R7 half");
      end
    end
    idle(50);
    finish_run();
  end

endmodule